// File: doc/BRIEF.md
# Committed-Store Writeback Queue

This block is a circular store queue for one thread of an out-of-order core. Stores take a slot at the tail when they are dispatched, and each dispatch gets back the slot index. When a store executes, its address, byte size and data are written into its slot. A commit input with a sequence number marks the stores older than that number as committed. A separate writeback pointer walks from the oldest unsent store towards the tail and offers each committed, executed store to the data memory port in program order. A slot is returned to the free pool only after the memory side reports that its write has completed. A squash input removes every store younger than a given sequence number by pulling the tail back.

Dispatch and writeback are valid/ready streams. A dispatch is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while the queue is full and in any cycle with a squash. A writeback is taken when `wb_valid` and `wb_ready` are both high. If the port refuses an offer (valid high, ready low), the block does not keep the offer up. It marks itself blocked, drops `wb_valid`, and offers the same entry again only after a `wb_retry` pulse. Execute, commit, squash and completion are plain single-cycle strobes.

The ring has `SLOTS` slots, one of which always stays empty, so the queue holds at most `SLOTS-1` stores.

Top module: `sq_store_queue`

## Requirements
- R1: After a synchronous reset the queue is empty: `free_cnt` = SLOTS-1, `full` = 0, `wb_valid` = 0, `pend_cnt` = 0, `alloc_idx` = 0.
- R2: A dispatch is taken only when `alloc_valid` and `alloc_ready` are both high. It gets the slot shown on `alloc_idx`, and the tail then advances by one. `full` rises and `alloc_ready` falls once SLOTS-1 stores are held. A dispatch offered while the queue is full changes neither `free_cnt` nor `alloc_idx`.
- R3: The head, writeback and tail indices step from SLOTS-1 back to 0.
- R4: Writebacks are offered in slot order from the writeback pointer. `wb_idx`, `wb_addr`, `wb_size` and `wb_data` carry that slot's recorded values. Each accepted offer moves the pointer on by one slot.
- R5: A commit marks only the held stores whose sequence number is strictly below `commit_seq`. A store is offered for writeback only when it is both committed and executed (a recorded size that is not zero), in either order of those two events.
- R6: A squash removes every held store whose sequence number is above `squash_seq` by moving the tail back. `alloc_ready` is low in a squash cycle, so a dispatch offered then is ignored.
- R7: A refused offer (valid high, ready low, no retry) blocks the port. `wb_valid` stays low until a `wb_retry` pulse, and the same entry is then offered again.
- R8: A slot is freed only after `done_valid` reports its completion. The head moves past completed slots one per cycle. A completion for the head slot frees it at the same clock edge.
- R9: `pend_cnt` counts committed, executed stores that have not yet been accepted, and `pend_any` is high when that count is nonzero. A commit and an accepted writeback in the same cycle both take effect.
- R10: `free_cnt` equals SLOTS-1 minus the number of held stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | A dispatch is offered |
| alloc_seq | input | SEQ_W | Sequence number of the dispatched store |
| alloc_ready | output | 1 | A dispatch can be taken |
| alloc_idx | output | IDX_W | Slot that the dispatch receives |
| exec_valid | input | 1 | A store has executed |
| exec_idx | input | IDX_W | Slot of the executed store |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | SIZE_W | Store size in bytes, nonzero |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | SEQ_W | Stores older than this number are committed |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Stores younger than this number are removed |
| wb_valid | output | 1 | A writeback is offered |
| wb_ready | input | 1 | The memory port takes the offer |
| wb_idx | output | IDX_W | Slot of the offered store |
| wb_addr | output | ADDR_W | Address of the offered store |
| wb_size | output | SIZE_W | Size of the offered store |
| wb_data | output | DATA_W | Data of the offered store |
| wb_retry | input | 1 | The memory port may be tried again |
| done_valid | input | 1 | A writeback has completed |
| done_idx | input | IDX_W | Slot whose writeback has completed |
| full | output | 1 | SLOTS-1 stores are held |
| free_cnt | output | CNT_W | Number of free usable slots |
| pend_cnt | output | CNT_W | Stores that are ready but not yet accepted |
| pend_any | output | 1 | `pend_cnt` is nonzero |

## Verification
Two functions can fall in one cycle: a commit that makes new stores writeback-ready, and an accepted writeback that retires one. The bench sets this up by executing two uncommitted stores while a first committed store is already on offer with `wb_ready` high. It then raises the commit in the same cycle as the acceptance. The count afterwards must be the old count minus one plus two, and the next offer must come from the following slot. A second collision, a squash together with a dispatch, is checked by confirming that the free count after the edge reflects only the squash.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Per-slot status flags
  typedef struct packed {
    logic committed;
    logic can_wb;
    logic completed;
  } sq_flags_t;

  localparam sq_flags_t SQ_FLAGS_CLEAR = '0;

endpackage

// File: rtl/sq_ring_ctl.sv
module sq_ring_ctl #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_go,
  input  logic             head_go,
  input  logic             wb_go,
  input  logic             squash_go,
  input  logic [CNT_W-1:0] keep_cnt,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] wbptr,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  localparam int SUM_W = CNT_W + 1;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [SUM_W-1:0] occ_sum;
  logic [SUM_W-1:0] cut_sum;
  logic [IDX_W-1:0] cut_tail;

  // Number of held stores, with the wrap taken into account
  always_comb begin
    if (tail >= head) occ_sum = SUM_W'(tail) - SUM_W'(head);
    else              occ_sum = SUM_W'(tail) + SUM_W'(SLOTS) - SUM_W'(head);
    count = CNT_W'(occ_sum);
  end

  // Tail after a squash: head plus the stores that survive
  always_comb begin
    cut_sum = SUM_W'(head) + SUM_W'(keep_cnt);
    if (cut_sum >= SUM_W'(SLOTS)) cut_sum = cut_sum - SUM_W'(SLOTS);
    cut_tail = IDX_W'(cut_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      wbptr <= '0;
      tail  <= '0;
    end else begin
      if (head_go) head <= step(head);
      if (wb_go)   wbptr <= step(wbptr);
      if (squash_go)     tail <= cut_tail;
      else if (alloc_go) tail <= step(tail);
    end
  end

endmodule

// File: rtl/sq_entry_file.sv
module sq_entry_file
  import sq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  wbptr,
  input  logic [IDX_W-1:0]  tail,
  input  logic [CNT_W-1:0]  count,
  input  logic              alloc_go,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              exec_go,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_go,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              done_go,
  input  logic [IDX_W-1:0]  done_idx,
  output logic [CNT_W-1:0]  keep_cnt,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              wb_ok,
  output logic              head_go,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic [DATA_W-1:0] wb_data
);

  localparam int SUM_W = CNT_W + 1;

  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [SIZE_W-1:0] size_q [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];
  sq_flags_t         flg_q  [SLOTS];

  logic [SLOTS-1:0] live;
  logic [SLOTS-1:0] pend;
  logic [SLOTS-1:0] keep;
  logic [SUM_W-1:0] wb_rank;

  always_comb begin
    if (wbptr >= head) wb_rank = SUM_W'(wbptr) - SUM_W'(head);
    else               wb_rank = SUM_W'(wbptr) + SUM_W'(SLOTS) - SUM_W'(head);
  end

  // Per-slot distance from head decides membership and writeback order
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SUM_W-1:0] rank;
    always_comb begin
      if (IDX_W'(g) >= head) rank = SUM_W'(g) - SUM_W'(head);
      else                   rank = SUM_W'(g) + SUM_W'(SLOTS) - SUM_W'(head);
    end
    assign live[g] = rank < SUM_W'(count);
    assign pend[g] = live[g] && (rank >= wb_rank) && flg_q[g].can_wb && !flg_q[g].completed;
    assign keep[g] = live[g] && (seq_q[g] <= squash_seq);
  end

  always_comb begin
    keep_cnt = '0;
    pend_cnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      keep_cnt = keep_cnt + CNT_W'(keep[i]);
      pend_cnt = pend_cnt + CNT_W'(pend[i]);
    end
  end

  assign wb_ok   = (wbptr != tail) && flg_q[wbptr].can_wb && !flg_q[wbptr].completed;
  assign head_go = live[head] && (flg_q[head].completed || (done_go && done_idx == head));
  assign wb_addr = addr_q[wbptr];
  assign wb_size = size_q[wbptr];
  assign wb_data = data_q[wbptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (rst) begin
        flg_q[i]  <= SQ_FLAGS_CLEAR;
        seq_q[i]  <= '0;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end else if (alloc_go && tail == IDX_W'(i)) begin
        flg_q[i]  <= SQ_FLAGS_CLEAR;
        seq_q[i]  <= alloc_seq;
        addr_q[i] <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end else if (live[i]) begin
        logic exec_hit, commit_hit, executed_n, committed_n;
        exec_hit    = exec_go && exec_idx == IDX_W'(i);
        commit_hit  = commit_go && (seq_q[i] < commit_seq);
        executed_n  = (size_q[i] != '0) || exec_hit;
        committed_n = flg_q[i].committed || commit_hit;
        if (exec_hit) begin
          addr_q[i] <= exec_addr;
          size_q[i] <= exec_size;
          data_q[i] <= exec_data;
        end
        flg_q[i].committed <= committed_n;
        flg_q[i].can_wb    <= committed_n && executed_n;
        if (done_go && done_idx == IDX_W'(i)) flg_q[i].completed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sq_wb_port.sv
module sq_wb_port (
  input  logic clk,
  input  logic rst,
  input  logic wb_ok,
  input  logic wb_ready,
  input  logic wb_retry,
  output logic wb_valid,
  output logic wb_go
);

  logic blocked;

  assign wb_valid = wb_ok && !blocked;
  assign wb_go    = wb_valid && wb_ready;

  always_ff @(posedge clk) begin
    if (rst)                        blocked <= 1'b0;
    else if (wb_retry)              blocked <= 1'b0;
    else if (wb_valid && !wb_ready) blocked <= 1'b1;
  end

endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_retry,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  output logic              full,
  output logic [CNT_W-1:0]  free_cnt,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              pend_any
);

  logic [IDX_W-1:0] head, wbptr, tail;
  logic [CNT_W-1:0] count, keep_cnt;
  logic             alloc_go, head_go, wb_go, wb_ok;

  assign full        = count >= CNT_W'(SLOTS - 1);
  assign alloc_ready = !full && !squash_valid;
  assign alloc_go    = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;
  assign wb_idx      = wbptr;
  assign free_cnt    = CNT_W'(SLOTS - 1) - count;
  assign pend_any    = pend_cnt != '0;

  sq_ring_ctl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst(rst), .alloc_go(alloc_go), .head_go(head_go), .wb_go(wb_go),
    .squash_go(squash_valid), .keep_cnt(keep_cnt),
    .head(head), .wbptr(wbptr), .tail(tail), .count(count)
  );

  sq_entry_file #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) u_file (
    .clk(clk), .rst(rst), .head(head), .wbptr(wbptr), .tail(tail), .count(count),
    .alloc_go(alloc_go), .alloc_seq(alloc_seq),
    .exec_go(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_data(exec_data),
    .commit_go(commit_valid), .commit_seq(commit_seq), .squash_seq(squash_seq),
    .done_go(done_valid), .done_idx(done_idx),
    .keep_cnt(keep_cnt), .pend_cnt(pend_cnt), .wb_ok(wb_ok), .head_go(head_go),
    .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data)
  );

  sq_wb_port u_port (
    .clk(clk), .rst(rst), .wb_ok(wb_ok), .wb_ready(wb_ready), .wb_retry(wb_retry),
    .wb_valid(wb_valid), .wb_go(wb_go)
  );

endmodule

// File: rtl/sq_store_queue_sva.sv
module sq_store_queue_sva #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             squash_valid,
  input logic             full,
  input logic [CNT_W-1:0] free_cnt,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic             wb_retry,
  input logic [IDX_W-1:0] wb_idx,
  input logic             pend_any
);

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (free_cnt == CNT_W'(SLOTS - 1) && !wb_valid && !full)); // R1

  AST_FULL_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (rst)
    full |-> !alloc_ready); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=> (free_cnt <= $past(free_cnt))); // R2

  AST_WB_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_ready) |=>
      (wb_idx == (($past(wb_idx) == IDX_W'(SLOTS - 1)) ? '0 : $past(wb_idx) + 1'b1))); // R4

  AST_SQUASH_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    squash_valid |-> !alloc_ready); // R6

  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready && !wb_retry) |=> !wb_valid); // R7

  AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> pend_any); // R9

endmodule

bind sq_store_queue sq_store_queue_sva #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .squash_valid(squash_valid), .full(full), .free_cnt(free_cnt), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_retry(wb_retry), .wb_idx(wb_idx), .pend_any(pend_any)
);

// File: tb/sq_store_queue_test.sv
`timescale 1ns/1ps
module sq_store_queue_test;

  localparam int SLOTS = 8;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 0;
  logic [15:0] alloc_seq = 0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        exec_valid = 0;
  logic [2:0]  exec_idx = 0;
  logic [31:0] exec_addr = 0;
  logic [3:0]  exec_size = 0;
  logic [63:0] exec_data = 0;
  logic        commit_valid = 0;
  logic [15:0] commit_seq = 0;
  logic        squash_valid = 0;
  logic [15:0] squash_seq = 0;
  logic        wb_valid;
  logic        wb_ready = 0;
  logic [2:0]  wb_idx;
  logic [31:0] wb_addr;
  logic [3:0]  wb_size;
  logic [63:0] wb_data;
  logic        wb_retry = 0;
  logic        done_valid = 0;
  logic [2:0]  done_idx = 0;
  logic        full;
  logic [3:0]  free_cnt;
  logic [3:0]  pend_cnt;
  logic        pend_any;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sq_store_queue #(.SLOTS(SLOTS)) uut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .exec_valid(exec_valid),
    .exec_idx(exec_idx), .exec_addr(exec_addr), .exec_size(exec_size), .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq), .squash_valid(squash_valid),
    .squash_seq(squash_seq), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx),
    .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data), .wb_retry(wb_retry),
    .done_valid(done_valid), .done_idx(done_idx), .full(full), .free_cnt(free_cnt),
    .pend_cnt(pend_cnt), .pend_any(pend_any)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock edge, then settle away from it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [15:0] seq, input logic [2:0] exp_idx);
    alloc_valid = 1; alloc_seq = seq;
    #0.5;
    check("R2", "alloc_ready", alloc_ready, 1);
    check("R2", "alloc_idx", alloc_idx, exp_idx);
    step();
    alloc_valid = 0;
  endtask

  task automatic do_exec(input logic [2:0] idx, input logic [31:0] a, input logic [63:0] d);
    exec_valid = 1; exec_idx = idx; exec_addr = a; exec_size = 4'd8; exec_data = d;
    step();
    exec_valid = 0;
  endtask

  task automatic do_done(input logic [2:0] idx);
    done_valid = 1; done_idx = idx;
    step();
    done_valid = 0;
  endtask

  task automatic t_reset();
    check("R1", "free_cnt", free_cnt, 7);
    check("R1", "full", full, 0);
    check("R1", "wb_valid", wb_valid, 0);
    check("R1", "pend_cnt", pend_cnt, 0);
    check("R1", "alloc_idx", alloc_idx, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 7; i++) do_alloc(16'(10 + i), 3'(i));
    check("R2", "full", full, 1);
    check("R2", "alloc_ready when full", alloc_ready, 0);
    check("R10", "free_cnt full", free_cnt, 0);
    alloc_valid = 1; alloc_seq = 16'd50;
    step();
    alloc_valid = 0;
    check("R2", "free_cnt after refused dispatch", free_cnt, 0);
    check("R2", "alloc_idx after refused dispatch", alloc_idx, 7);
  endtask

  task automatic t_commit_exec();
    commit_valid = 1; commit_seq = 16'd12;
    step();
    commit_valid = 0;
    check("R5", "no offer before execute", wb_valid, 0);
    check("R5", "pend before execute", pend_cnt, 0);
    do_exec(3'd0, 32'h1000, 64'h1111);
    check("R4", "offer valid", wb_valid, 1);
    check("R4", "offer idx", wb_idx, 0);
    check("R4", "offer addr", wb_addr, 32'h1000);
    check("R4", "offer data", wb_data, 64'h1111);
    check("R4", "offer size", wb_size, 8);
    check("R9", "pend one", pend_cnt, 1);
    // the offer is refused at this edge
    do_exec(3'd1, 32'h1008, 64'h2222);
    check("R7", "offer dropped after refusal", wb_valid, 0);
    do_exec(3'd2, 32'h1010, 64'h3333);
    do_exec(3'd3, 32'h1018, 64'h4444);
    check("R7", "still blocked", wb_valid, 0);
    check("R5", "uncommitted executed not pending", pend_cnt, 2);
    check("R9", "pend_any", pend_any, 1);
  endtask

  task automatic t_retry();
    wb_retry = 1; wb_ready = 1;
    step();
    wb_retry = 0;
    check("R7", "reoffer after retry", wb_valid, 1);
    check("R7", "same entry", wb_idx, 0);
  endtask

  task automatic t_commit_and_accept();
    commit_valid = 1; commit_seq = 16'd14;
    step();
    commit_valid = 0;
    check("R9", "commit with accept", pend_cnt, 3);
    check("R4", "next idx 1", wb_idx, 1);
    check("R4", "next data 1", wb_data, 64'h2222);
    step();
    check("R4", "next idx 2", wb_idx, 2);
    check("R4", "next addr 2", wb_addr, 32'h1010);
    step();
    check("R4", "next idx 3", wb_idx, 3);
    check("R4", "next data 3", wb_data, 64'h4444);
    step();
    wb_ready = 0;
    check("R5", "seq 14 not committed", wb_valid, 0);
    check("R9", "pend drained", pend_cnt, 0);
    check("R9", "pend_any low", pend_any, 0);
  endtask

  task automatic t_complete();
    do_done(3'd1);
    check("R8", "out-of-order done keeps slot", free_cnt, 0);
    do_done(3'd0);
    check("R8", "head done frees now", free_cnt, 1);
    step();
    check("R8", "contiguous done freed", free_cnt, 2);
    step();
    check("R8", "undone head waits", free_cnt, 2);
  endtask

  task automatic t_squash();
    squash_valid = 1; squash_seq = 16'd14;
    alloc_valid = 1; alloc_seq = 16'd99;
    #0.5;
    check("R6", "alloc_ready low in squash", alloc_ready, 0);
    step();
    squash_valid = 0; alloc_valid = 0;
    check("R6", "free after squash", free_cnt, 4);
    check("R6", "tail moved back", alloc_idx, 5);
  endtask

  task automatic t_wrap();
    do_alloc(16'd20, 3'd5);
    do_alloc(16'd21, 3'd6);
    do_alloc(16'd22, 3'd7);
    do_alloc(16'd23, 3'd0);
    check("R3", "tail wrapped", alloc_idx, 1);
    check("R3", "full after wrap", full, 1);
    check("R10", "free after wrap", free_cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    #1;
    t_reset();
    t_fill();
    t_commit_exec();
    t_retry();
    t_commit_and_accept();
    t_complete();
    t_squash();
    t_wrap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule